// File: doc/BRIEF.md
# SAR Conversion Sequencer with Run-Time Resolution

This block sets the timing of one successive-approximation conversion. A start pulse opens a sampling window of programmable length. A bit-by-bit search follows, from the most significant trial bit downwards. Each trial word goes to an external DAC, and a comparator reports whether the held input is at or above it. Four resolutions (12, 10, 8 or 6 bits) can be chosen for each conversion. A lower resolution shortens only the search phase, not the sampling phase.

The block runs on a clock at twice the converter rate, so one clock period equals half a converter cycle. The half-cycle terms of the conversion time are therefore whole clock periods. A conversion of R bits with a sampling window of S periods takes S + 2R + 1 periods from the accepted start to the done pulse. The result appears in a 12-bit word with the selected number of bits at the top. Every bit below the selected resolution is zero.

Top module: `sar_conv_seq`

## Requirements
- R1: While rst_ni is low, and after its release, dac_o, samp_en_o, samp_end_o, conv_done_o and result_o are all zero.
- R2: res_sel_i picks the resolution: 00 gives 12 bits, 01 gives 10, 10 gives 8 and 11 gives 6. With an ideal comparator (comp_i = 1 when the input is at or above dac_o), result_o equals the 12-bit input with its lowest 12−R bits cleared.
- R3: samp_en_o is high for exactly S consecutive cycles, starting in the cycle after the start is accepted. S is samp_len_i, and a value of 0 counts as 1.
- R4: samp_end_o is a single-cycle pulse in the first cycle after samp_en_o falls.
- R5: conv_done_o is a single-cycle pulse that rises S + 2R + 1 clock edges after the edge that accepted the start.
- R6: dac_o is 0x800 for the first three search cycles. Bit n is decided at the end of the second cycle for which it is the trial bit: comp_i = 1 keeps it, comp_i = 0 clears it. The next lower bit is then set as the new trial bit.
- R7: A start_i pulse that arrives while sampling or searching is ignored. It causes no extra done pulse and no restart.
- R8: res_sel_i and samp_len_i are captured at the accepted start. Changing them during a conversion has no effect on that conversion.
- R9: result_o holds its value until the next done pulse. dac_o is zero while the block is idle.
- R10: A start pulse in the same cycle as conv_done_o is accepted, and sampling begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the converter rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| res_sel_i | input | 2 | Resolution select |
| samp_len_i | input | SAMP_W | Sampling window length in clock periods |
| comp_i | input | 1 | Comparator decision, 1 = input at or above dac_o |
| dac_o | output | DATA_W | Trial word to the DAC |
| samp_en_o | output | 1 | Sample switch enable |
| samp_end_o | output | 1 | Pulse when sampling ends |
| conv_done_o | output | 1 | Pulse when result_o is updated |
| result_o | output | DATA_W | Last conversion result, low unused bits zero |

## Verification
The end of one conversion and the acceptance of the next can fall in the same cycle. This is provoked by raising start_i in the very cycle that conv_done_o is high. The bench then requires samp_en_o on the following cycle and a correct result and latency for the second conversion. A start pulse is also driven in the middle of a search, together with a changed resolution and sampling length. That conversion is judged on a single done pulse at the original latency and a result truncated to the original resolution.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  // resolution in bits for a 2-bit select: each code step drops two bits
  function automatic int res_bits(input int data_w, input logic [1:0] sel);
    return data_w - 2 * int'(sel);
  endfunction
endpackage

// File: rtl/sar_samp_cnt.sv
module sar_samp_cnt #(
  parameter int SAMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SAMP_W-1:0] len_i,
  output logic              active_o,
  output logic              last_o
);
  logic [SAMP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - SAMP_W'(1);
  end

  assign active_o = (cnt_q != '0);
  assign last_o   = (cnt_q == SAMP_W'(1));

  // the sequencer may only open a window when none is running
  p_no_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !active_o);
  p_len_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_o);
endmodule

// File: rtl/sar_step_cnt.sv
module sar_step_cnt #(
  parameter int STEP_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [STEP_W-1:0] limit_i,
  output logic              decide_o,
  output logic              last_o
);
  logic [STEP_W-1:0] k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      k_q <= '0;
    else if (load_i)  k_q <= '0;
    else if (run_i)   k_q <= k_q + STEP_W'(1);
  end

  // cycle 0 is the extra half cycle; every even cycle after it closes a bit
  assign decide_o = run_i && (k_q != '0) && !k_q[0];
  assign last_o   = run_i && (k_q == limit_i);

  p_step_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> k_q <= limit_i);
  p_last_decides_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> decide_o);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              decide_i,
  input  logic              last_i,
  input  logic              comp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] resolved_o
);
  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] ptr_q, trial_q;

  assign resolved_o = comp_i ? trial_q : (trial_q & ~ptr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      trial_q <= '0;
    end else if (load_i) begin
      ptr_q   <= MSB_ONLY;
      trial_q <= MSB_ONLY;
    end else if (decide_i) begin
      if (last_i) begin
        ptr_q   <= '0;
        trial_q <= '0;
      end else begin
        ptr_q   <= ptr_q >> 1;
        trial_q <= resolved_o | (ptr_q >> 1);
      end
    end
  end

  assign trial_o = trial_q;

  p_ptr_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ptr_q));
  p_keep_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && comp_i && !last_i && !load_i) |=> (trial_q & $past(ptr_q)) != '0);
  p_drop_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !comp_i && !last_i && !load_i) |=> (trial_q & $past(ptr_q)) == '0);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int DATA_W = 12,
  parameter int SAMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        res_sel_i,
  input  logic [SAMP_W-1:0] samp_len_i,
  input  logic              comp_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              samp_en_o,
  output logic              samp_end_o,
  output logic              conv_done_o,
  output logic [DATA_W-1:0] result_o
);
  import sar_seq_pkg::*;

  localparam int STEP_W = $clog2(2 * DATA_W + 1);

  seq_state_e        state_q;
  logic [1:0]        res_q;
  logic              start_acc, samp_active, samp_last;
  logic              step_decide, step_last, conv_run;
  logic [STEP_W-1:0] step_limit;
  logic [SAMP_W-1:0] samp_len_eff;
  logic [DATA_W-1:0] keep_mask, resolved;
  logic              samp_end_q, done_q;
  logic [DATA_W-1:0] result_q;

  assign start_acc    = start_i && (state_q == ST_IDLE);
  assign samp_len_eff = (samp_len_i == '0) ? SAMP_W'(1) : samp_len_i;
  assign conv_run     = (state_q == ST_CONV);
  assign step_limit   = STEP_W'(2 * res_bits(DATA_W, res_q));
  assign keep_mask    = ~((DATA_W'(1) << {res_q, 1'b0}) - DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_acc) begin
          state_q <= ST_SAMP;
          res_q   <= res_sel_i;
        end
        ST_SAMP: if (samp_last) state_q <= ST_CONV;
        ST_CONV: if (step_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sar_samp_cnt #(.SAMP_W(SAMP_W)) u_samp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_acc),
    .len_i    (samp_len_eff),
    .active_o (samp_active),
    .last_o   (samp_last)
  );

  sar_step_cnt #(.STEP_W(STEP_W)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (samp_last),
    .run_i    (conv_run),
    .limit_i  (step_limit),
    .decide_o (step_decide),
    .last_o   (step_last)
  );

  sar_trial_reg #(.DATA_W(DATA_W)) u_trial (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (samp_last),
    .decide_i   (step_decide),
    .last_i     (step_last),
    .comp_i     (comp_i),
    .trial_o    (dac_o),
    .resolved_o (resolved)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_end_q <= 1'b0;
      done_q     <= 1'b0;
      result_q   <= '0;
    end else begin
      samp_end_q <= samp_last;
      done_q     <= step_last;
      if (step_last) result_q <= resolved & keep_mask;
    end
  end

  assign samp_en_o   = samp_active;
  assign samp_end_o  = samp_end_q;
  assign conv_done_o = done_q;
  assign result_o    = result_q;

  p_samp_end_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_end_o |-> ($past(samp_en_o) && !samp_en_o));
  p_trial_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_run |-> (dac_o & ~keep_mask) == '0);
  p_result_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (result_o & ~keep_mask) == '0);
  p_res_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(res_q));
  p_idle_dac_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> dac_o == '0);
  p_pulses_apart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({samp_end_o, conv_done_o}));
  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_o |-> $stable(result_o));
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  res_sel = '0;
  logic [7:0]  samp_len = '0;
  logic [11:0] vin = '0;
  logic        comp;
  logic [11:0] dac, result;
  logic        samp_en, samp_end, done;
  int          vectors = 0;
  int          miscompares = 0;

  always #10 clk = ~clk;

  assign comp = (vin >= dac);

  sar_conv_seq #(.DATA_W(12), .SAMP_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .res_sel_i(res_sel),
    .samp_len_i(samp_len), .comp_i(comp), .dac_o(dac), .samp_en_o(samp_en),
    .samp_end_o(samp_end), .conv_done_o(done), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] keep(input logic [1:0] c);
    return 12'hFFF & ~((12'h1 << (2 * c)) - 12'h1);
  endfunction

  // called at a negedge; start is sampled at the next posedge
  task automatic do_conv(input logic [1:0] c, input logic [7:0] s,
                         input logic [11:0] v, input bit disturb);
    int se, rb, lim, en_cnt, end_idx, done_idx, done_cnt;
    logic [11:0] dac0, dac3, res_at_done, exp_res;
    se = (s == 0) ? 1 : int'(s);
    rb = 12 - 2 * int'(c);
    lim = se + 2 * rb + 4;
    en_cnt = 0; end_idx = 0; done_idx = 0; done_cnt = 0;
    dac0 = '0; dac3 = '0; res_at_done = '0;
    exp_res = v & keep(c);
    vin = v; res_sel = c; samp_len = s; start = 1'b1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      if (disturb && i == se + 2) begin
        start = 1'b1; res_sel = ~c; samp_len = s + 8'd5;
      end
      if (disturb && i == se + 4) begin
        start = 1'b0; res_sel = c; samp_len = s;
      end
      if (samp_en) en_cnt++;
      if (samp_end && end_idx == 0) end_idx = i;
      if (done) begin
        done_cnt++;
        if (done_idx == 0) begin done_idx = i; res_at_done = result; end
      end
      if (i == se + 1) dac0 = dac;
      if (i == se + 4) dac3 = dac;
    end
    chk(en_cnt == se, "R3 sample window", en_cnt, se);
    chk(end_idx == se + 1, "R4 sample end pulse", end_idx, se + 1);
    chk(done_idx == se + 2 * rb + 2, "R5 latency", done_idx, se + 2 * rb + 2);
    chk(done_cnt == 1, disturb ? "R7 single done" : "R5 single done", done_cnt, 1);
    chk(dac0 == 12'h800, "R6 first trial", dac0, 12'h800);
    chk(dac3 == ((v & 12'h800) | 12'h400), "R6 after first decision", dac3,
        (v & 12'h800) | 12'h400);
    chk(res_at_done == exp_res, disturb ? "R8 result" : "R2 result", res_at_done, exp_res);
    chk(result == exp_res, "R9 result hold", result, exp_res);
    chk(dac == 12'h000, "R9 idle dac", dac, 0);
  endtask

  task automatic back_to_back();
    int idx;
    vin = 12'h9F0; res_sel = 2'b11; samp_len = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    while (!done && idx < 40) begin @(negedge clk); idx++; end
    chk(result == 12'h9C0, "R2 6-bit result", result, 12'h9C0);
    start = 1'b1; res_sel = 2'b10; samp_len = 8'd2; vin = 12'h5AB;
    @(negedge clk);
    start = 1'b0;
    chk(samp_en == 1'b1, "R10 restart on done", samp_en, 1);
    chk(done == 1'b0, "R10 no done", done, 0);
    idx = 1;
    while (!done && idx < 40) begin @(negedge clk); idx++; end
    chk(idx == 20, "R10 second latency", idx, 20);
    chk(result == 12'h5A0, "R10 second result", result, 12'h5A0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({dac, samp_en, samp_end, done, result} == '0, "R1 in reset",
        int'({dac, result}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({dac, samp_en, samp_end, done, result} == '0, "R1 after reset",
        int'({dac, result}), 0);
    do_conv(2'b00, 8'd3, 12'hA5C, 1'b0);
    do_conv(2'b01, 8'd0, 12'h7FF, 1'b0);
    do_conv(2'b10, 8'd5, 12'hFFF, 1'b0);
    do_conv(2'b11, 8'd2, 12'h0C3, 1'b0);
    do_conv(2'b00, 8'd1, 12'h000, 1'b0);
    do_conv(2'b01, 8'd4, 12'h3A7, 1'b1);
    back_to_back();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule